// File: doc/BRIEF.md
# Zero-Crossing Synchronized Burst Gate

This block produces the enable for a resonant bridge driver. Two asynchronous inputs control it. The first is an interrupter pulse that frames each burst. The second is a digitized current-feedback square wave, and every edge of that wave marks a zero crossing of the bridge current. Drive turns on while the interrupter is active. When the interrupter ends, the gate does not drop drive at once. It arms and keeps drive on until the next qualifying feedback edge, so the bridge always stops switching at a current zero crossing.

If feedback never arrives, for example when the resonator fails to ring up, a countdown started at the end of the interrupter pulse forces drive off. A one-cycle status pulse flags that fallback. The countdown length is set at run time in system clocks. It should be about two RF periods, so that it never cuts a burst short before the real feedback edge has had a chance to arrive. Both asynchronous inputs pass through two-flop synchronizers before any decision is made. All pins are plain control and status levels, so there is no stream handshake and no back-pressure.

Top module: `zc_burst_gate`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `drive_en` = 0 and `wdog_trip` = 0, and the gate is idle.
- R2: `intr_in` and `fb_in` each pass through two flops. If `intr_in` rises while the gate is idle, `drive_en` goes high at the third rising clock edge after the change.
- R3: While the synchronized interrupter is high, `drive_en` is 1 and feedback transitions have no effect. When the gate is idle, feedback transitions leave `drive_en` at 0.
- R4: After the synchronized interrupter goes low, `drive_en` stays 1 until the first qualifying feedback transition. `drive_en` goes low at the third rising edge after that `fb_in` change, and `wdog_trip` stays 0.
- R5: With `cfg_rise_only` = 0, a change of `fb_in` in either direction qualifies. With `cfg_rise_only` = 1, only a 0-to-1 change qualifies and a 1-to-0 change is ignored.
- R6: If no qualifying transition arrives, `drive_en` goes low max(`cfg_timeout`,1) cycles after the cycle in which the gate arms. With `intr_in` falling before edge k, that is at edge k+2+max(T,1).
- R7: `wdog_trip` is high for exactly one cycle, in the cycle where a countdown expiry has just turned `drive_en` off. It never pulses when a feedback edge ends the burst.
- R8: If a qualifying feedback edge and the countdown expiry fall in the same cycle, the feedback edge wins and `wdog_trip` stays 0.
- R9: If the interrupter reasserts while the gate is armed, the burst restarts without `drive_en` dropping, and the countdown restarts in full at the next arming.
- R10: `cfg_timeout` is captured at the moment of arming. Changing it later does not alter the current countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| intr_in | input | 1 | Asynchronous interrupter pulse, active high |
| fb_in | input | 1 | Asynchronous digitized current feedback |
| cfg_timeout | input | TMO_W | Fallback countdown in clocks, captured at arming |
| cfg_rise_only | input | 1 | 1: only rising feedback edges end a burst |
| drive_en | output | 1 | Bridge drive enable |
| wdog_trip | output | 1 | One-cycle pulse when the countdown ended a burst |

## Verification
The gate is exercised with feedback toggling during a burst, which tests the override. Feedback held still after the interrupter falls separates a feedback-terminated burst from a watchdog-terminated one. A falling-only transition under rise-only mode shows which polarity qualifies. A feedback edge placed in exactly the expiry cycle exposes the priority between the two terminations. An interrupter re-pulse during the countdown, and a timeout change after arming, show whether the countdown is cleared and when the timeout is sampled. Minimum timeouts of 0 and 1 probe the boundary of the countdown.

// File: rtl/zcb_pkg.sv
package zcb_pkg;
  typedef enum logic [1:0] {
    ZC_IDLE  = 2'd0,
    ZC_BURST = 2'd1,
    ZC_ARMED = 2'd2
  } zc_state_e;
endpackage

// File: rtl/zcb_sync.sv
// Multi-flop synchronizer for one asynchronous level.
module zcb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/zcb_edge.sv
// Edge detector on an already synchronized level.
module zcb_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic any
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign any  = lvl ^ prev_q;
endmodule

// File: rtl/zcb_wdog.sv
// Fallback countdown: loaded at arming, counts while running.
module zcb_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (run && !expire)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/zc_burst_gate.sv
module zc_burst_gate #(
  parameter int TMO_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             intr_in,
  input  logic             fb_in,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             cfg_rise_only,
  output logic             drive_en,
  output logic             wdog_trip
);
  import zcb_pkg::*;

  logic intr_s;
  logic fb_s;
  logic fb_rise;
  logic fb_any;
  logic fb_hit;
  logic wd_expire;
  logic wd_load;
  logic trip_d;
  logic trip_q;

  zc_state_e state_q, state_d;

  zcb_sync #(.STAGES(SYNC_DEPTH)) u_sync_intr (
    .clk(clk), .rst(rst), .d_async(intr_in), .q_sync(intr_s)
  );

  zcb_sync #(.STAGES(SYNC_DEPTH)) u_sync_fb (
    .clk(clk), .rst(rst), .d_async(fb_in), .q_sync(fb_s)
  );

  zcb_edge u_edge_fb (
    .clk(clk), .rst(rst), .lvl(fb_s), .rise(fb_rise), .any(fb_any)
  );

  assign fb_hit = cfg_rise_only ? fb_rise : fb_any;

  zcb_wdog #(.CNT_W(TMO_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .load     (wd_load),
    .run      (state_q == ZC_ARMED),
    .load_val (cfg_timeout),
    .expire   (wd_expire)
  );

  always_comb begin
    state_d = state_q;
    wd_load = 1'b0;
    trip_d  = 1'b0;
    if (intr_s) begin
      state_d = ZC_BURST;
    end else begin
      unique case (state_q)
        ZC_BURST: begin
          state_d = ZC_ARMED;
          wd_load = 1'b1;
        end
        ZC_ARMED: begin
          if (fb_hit) begin
            state_d = ZC_IDLE;
          end else if (wd_expire) begin
            state_d = ZC_IDLE;
            trip_d  = 1'b1;
          end
        end
        default: state_d = ZC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ZC_IDLE;
      trip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trip_q  <= trip_d;
    end
  end

  assign drive_en  = (state_q != ZC_IDLE);
  assign wdog_trip = trip_q;
endmodule

// File: rtl/zcb_chk.sv
module zcb_chk (
  input logic clk,
  input logic rst,
  input logic intr_s,
  input logic fb_hit,
  input logic drive_en,
  input logic wdog_trip
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!drive_en && !wdog_trip));

  // R3
  intr_forces_on_chk: assert property (@(posedge clk) disable iff (rst)
    intr_s |=> drive_en);

  // R2
  rise_needs_intr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> $past(intr_s));

  // R4
  fb_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(drive_en) && !wdog_trip) |-> $past(fb_hit));

  // R7
  trip_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_trip |-> (!drive_en && $past(drive_en)));

  // R7
  trip_single_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_trip |=> !wdog_trip);

  // R8
  fb_beats_trip_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_trip |-> !$past(fb_hit));
endmodule

bind zc_burst_gate zcb_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .intr_s    (intr_s),
  .fb_hit    (fb_hit),
  .drive_en  (drive_en),
  .wdog_trip (wdog_trip)
);

// File: tb/test_zc_burst_gate.sv
`timescale 1ns/1ps
module test_zc_burst_gate;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          intr_in = 1'b0;
  logic          fb_in = 1'b0;
  logic [TW-1:0] cfg_timeout = '0;
  logic          cfg_rise_only = 1'b0;
  logic          drive_en;
  logic          wdog_trip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  zc_burst_gate #(.TMO_W(TW)) i_zc_burst_gate (
    .clk(clk), .rst(rst), .intr_in(intr_in), .fb_in(fb_in),
    .cfg_timeout(cfg_timeout), .cfg_rise_only(cfg_rise_only),
    .drive_en(drive_en), .wdog_trip(wdog_trip)
  );

  // Behavioural reference: input histories plus a burst phase.
  bit ih[$];
  bit fh[$];
  int m_phase = 0;   // 0 off, 1 in burst, 2 waiting for zero crossing
  int m_left = 0;
  bit m_trip = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin ih.push_back(0); fh.push_back(0); end
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin ih[i] = 0; fh[i] = 0; end
      m_phase = 0; m_left = 0; m_trip = 0;
    end else begin
      bit iv, fnew, fold, hit;
      ih.push_front(intr_in); void'(ih.pop_back());
      fh.push_front(fb_in);   void'(fh.pop_back());
      iv = ih[2]; fnew = fh[2]; fold = fh[3];
      hit = cfg_rise_only ? (fnew && !fold) : (fnew != fold);
      m_trip = 0;
      if (iv) m_phase = 1;
      else if (m_phase == 1) begin m_phase = 2; m_left = int'(cfg_timeout); end
      else if (m_phase == 2) begin
        if (hit) m_phase = 0;
        else if (m_left <= 1) begin m_phase = 0; m_trip = 1; end
        else m_left--;
      end
    end
  end

  task automatic check(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(tag, drive_en, logic'(m_phase != 0), "model drive_en");
      check(tag, wdog_trip, logic'(m_trip), "model wdog_trip");
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    check("R1", drive_en, 1'b0, "reset drive_en");
    check("R1", wdog_trip, 1'b0, "reset wdog_trip");
    rst = 1'b0;
    idle(2);

    // R3: feedback in idle has no effect
    tag = "R3";
    fb_in = 1'b1; idle(4); fb_in = 1'b0; idle(4);
    check("R3", drive_en, 1'b0, "idle ignores feedback");

    // R2 latency and R3 override
    tag = "R2";
    cfg_timeout = 16'd1000;
    intr_in = 1'b1;
    idle(2); check("R2", drive_en, 1'b0, "before sync delay");
    idle(1); check("R2", drive_en, 1'b1, "third edge");
    tag = "R3";
    for (int i = 0; i < 8; i++) begin fb_in = ~fb_in; idle(3); end
    check("R3", drive_en, 1'b1, "feedback ignored in burst");

    // R4: end at the first feedback edge
    tag = "R4";
    intr_in = 1'b0; idle(12);
    check("R4", drive_en, 1'b1, "held while armed");
    fb_in = ~fb_in;
    idle(2); check("R4", drive_en, 1'b1, "before fb sync");
    idle(1); check("R4", drive_en, 1'b0, "ended at zero crossing");
    check("R4", wdog_trip, 1'b0, "no trip on fb end");
    idle(4);

    // R5: rise-only ignores a falling edge
    tag = "R5";
    cfg_rise_only = 1'b1; fb_in = 1'b1; idle(4);
    intr_in = 1'b1; idle(6); intr_in = 1'b0; idle(5);
    fb_in = 1'b0; idle(6);
    check("R5", drive_en, 1'b1, "falling edge ignored");
    fb_in = 1'b1; idle(3);
    check("R5", drive_en, 1'b0, "rising edge ends");
    cfg_rise_only = 1'b0; idle(4);

    // R6/R7: countdown of 5
    tag = "R6";
    cfg_timeout = 16'd5;
    intr_in = 1'b1; idle(6); intr_in = 1'b0;
    idle(7); check("R6", drive_en, 1'b1, "still on at T+2");
    idle(1); check("R6", drive_en, 1'b0, "off at T+3");
    check("R7", wdog_trip, 1'b1, "trip pulse");
    idle(1); check("R7", wdog_trip, 1'b0, "trip one cycle");
    idle(3);

    // R6 boundary: timeout 0 acts as 1
    tag = "R6";
    cfg_timeout = 16'd0;
    intr_in = 1'b1; idle(6); intr_in = 1'b0;
    idle(3); check("R6", drive_en, 1'b1, "T0 on");
    idle(1); check("R6", drive_en, 1'b0, "T0 off");
    check("R7", wdog_trip, 1'b1, "T0 trip");
    idle(3);

    // R8: feedback and expiry in the same cycle
    tag = "R8";
    cfg_timeout = 16'd4;
    intr_in = 1'b1; idle(6); intr_in = 1'b0;
    idle(4); fb_in = ~fb_in;
    idle(3); check("R8", drive_en, 1'b0, "tie ends burst");
    check("R8", wdog_trip, 1'b0, "tie gives no trip");
    idle(4);

    // R9: re-pulse while armed
    tag = "R9";
    cfg_timeout = 16'd6;
    intr_in = 1'b1; idle(6); intr_in = 1'b0; idle(5);
    intr_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      idle(1); check("R9", drive_en, 1'b1, "no gap on re-pulse");
    end
    intr_in = 1'b0;
    idle(8); check("R9", drive_en, 1'b1, "full countdown restarted");
    idle(1); check("R9", drive_en, 1'b0, "restarted countdown ends");
    idle(3);

    // R10: timeout captured at arming
    tag = "R10";
    cfg_timeout = 16'd3;
    intr_in = 1'b1; idle(6); intr_in = 1'b0;
    idle(3); cfg_timeout = 16'd50;
    idle(2); check("R10", drive_en, 1'b1, "on before captured expiry");
    idle(1); check("R10", drive_en, 1'b0, "captured value used");
    idle(4);

    finish_run();
  end
endmodule